// File: doc/BRIEF.md
# Quad Reloadable Timer Unit

This block holds four 8-bit down-counting timers, each paired with an 8-bit reload latch, on a small byte-wide register bus. A timer advances only on a single-cycle count pulse. Each timer picks that pulse from its own set of sources: taps of a free-running prescaler on the system clock, rising edges on external pins, or the overflow of its neighbour. Chaining timer 1 into timer 2, or timer 3 into timer 4, gives a 16-bit divider in which the lower timer acts as an 8-bit prescaler.

When a count pulse arrives while a counter holds zero, the counter overflows. It reloads from its latch and sets a sticky interrupt request flag. A dedicated strobe input clears the flags. The whole block runs on one clock. External pins pass through a two-flop synchroniser and an edge detector before they reach the source selectors.

Top module: `qtmr_unit`

## Requirements
- R1: On each count pulse a counter holding a non-zero value decrements by one, so a timer with latch value n overflows once every n+1 count pulses (with the f/16 tap, once every 16*(n+1) clock cycles).
- R2: A bus write to offset 0, 1, 2 or 3 (timers 1 to 4) stores the byte in that timer's latch and loads it into the counter in the same cycle. A read of offsets 0 to 3 returns that timer's current counter value.
- R3: A count pulse that arrives while the counter is 00h makes an overflow: the counter reloads from the latch and the timer's request flag is set.
- R4: Request flags stay set until bit i of irq_clr is strobed. If an overflow and a clear land in the same cycle, the flag ends up set.
- R5: Timer 1's source is bit 0 of the mode register at offset 4: 0 selects f/16, 1 selects f/4096.
- R6: Timer 2's source is {bit 4, bit 1} of offset 4: 00 selects f/16, 01 selects timer 1 overflow, and 1x selects rising edges of pin_t2_clk.
- R7: Timer 3's source is {bit 5, bit 0} of offset 5: 00 selects f/16, 01 selects rising edges of pin_line_sync, and 1x selects rising edges of pin_t3_clk. Edges on a pin that is not selected have no effect.
- R8: Timer 4's source is {bit 4, bit 1} of offset 5: 00 selects f/16, 01 selects f/2, and 1x selects timer 3 overflow.
- R9: Each synchronised rising edge of an external pin gives exactly one count pulse. A pin held high gives no further pulses.
- R10: After reset, all latches and counters are FFh, both mode registers are 00h and all flags are clear. Reads of offsets 4 and 5 return the mode registers, and other offsets read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_t2_clk | input | 1 | External count pin for timer 2 |
| pin_line_sync | input | 1 | Line-sync count pin for timer 3 |
| pin_t3_clk | input | 1 | External count pin for timer 3 |
| irq_clr | input | 4 | Per-timer flag clear strobe |
| irq_req | output | 4 | Per-timer sticky overflow request flags |

## Verification
On every cycle the assertions check the counter arithmetic: decrement, reload on overflow and load on latch write. They also check flag set, hold and clear, the single-cycle nature of pin pulses, the alignment of the prescaler taps, and that a chained timer counts exactly its neighbour's overflows. The bench scenarios have to show the end-to-end division ratios for each source selection, counts of pin edges, that unselected pins are ignored, and that a set wins over a clear strobe in the same cycle. Those results depend on the mode encodings and on multi-cycle timing that no single-cycle property captures.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;
    localparam int TMR_N     = 4;
    localparam int TMR_W     = 8;
    localparam int PIN_N     = 3;
    localparam logic [TMR_W-1:0] LATCH_RST = 8'hFF;

    typedef struct packed {
        logic [TMR_W-1:0] latch;
        logic [TMR_W-1:0] cnt;
    } chan_st_t;

    typedef struct packed {
        logic [TMR_W-1:0] mode12;
        logic [TMR_W-1:0] mode34;
        logic [TMR_N-1:0] irq;
    } top_st_t;
endpackage

// File: rtl/qtmr_prescale.sv
module qtmr_prescale #(
    parameter int PRE_W   = 12,
    parameter int LO_LOG  = 1,
    parameter int MID_LOG = 4,
    parameter int HI_LOG  = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_lo,
    output logic tick_mid,
    output logic tick_hi
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
        tick_lo  = &st_q.pre[LO_LOG-1:0];
        tick_mid = &st_q.pre[MID_LOG-1:0];
        tick_hi  = &st_q.pre[HI_LOG-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    tick_hi_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_hi |-> tick_mid);
    // R8
    tick_mid_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_mid |-> tick_lo);
endmodule

// File: rtl/qtmr_edge.sv
module qtmr_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pins;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise    = st_q.s2 & ~st_q.s3;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9
        single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/qtmr_chan.sv
module qtmr_chan
    import qtmr_pkg::*;
#(
    parameter int W = TMR_W,
    parameter logic [W-1:0] RST_VAL = LATCH_RST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         pulse,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        if (ld) begin
            st_d.latch = ld_val;
            st_d.cnt   = ld_val;
        end else if (pulse) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.latch;
                ovf      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        cnt = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.latch <= RST_VAL;
            st_q.cnt   <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    // R1
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !ld && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !ld && cnt == '0) |=> cnt == $past(st_q.latch));
    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)) && (st_q.latch == $past(ld_val)));
    // R1
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && !ld) |=> $stable(cnt));
endmodule

// File: rtl/qtmr_unit.sv
module qtmr_unit
    import qtmr_pkg::*;
#(
    parameter int AW      = 3,
    parameter int PRE_W   = 12,
    parameter int LO_LOG  = 1,
    parameter int MID_LOG = 4,
    parameter int HI_LOG  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [TMR_W-1:0] bus_wdata,
    output logic [TMR_W-1:0] bus_rdata,
    input  logic             pin_t2_clk,
    input  logic             pin_line_sync,
    input  logic             pin_t3_clk,
    input  logic [TMR_N-1:0] irq_clr,
    output logic [TMR_N-1:0] irq_req
);
    localparam logic [AW-1:0] OFS_MODE12 = AW'(TMR_N);
    localparam logic [AW-1:0] OFS_MODE34 = AW'(TMR_N + 1);

    logic tick_lo, tick_mid, tick_hi;
    logic [PIN_N-1:0] rise;
    logic [TMR_N-1:0] ld, pulse, ovf;
    logic [TMR_W-1:0] cnt [TMR_N];
    logic [1:0] sel2, sel3, sel4;

    top_st_t st_d, st_q;

    qtmr_prescale #(
        .PRE_W(PRE_W), .LO_LOG(LO_LOG), .MID_LOG(MID_LOG), .HI_LOG(HI_LOG)
    ) u_pre (
        .clk(clk), .rst_n(rst_n),
        .tick_lo(tick_lo), .tick_mid(tick_mid), .tick_hi(tick_hi)
    );

    qtmr_edge #(.N(PIN_N)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .pins({pin_t3_clk, pin_line_sync, pin_t2_clk}),
        .rise(rise)
    );

    for (genvar i = 0; i < TMR_N; i++) begin : g_chan
        assign ld[i] = bus_wr && (bus_addr == AW'(i));
        qtmr_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .ld(ld[i]), .ld_val(bus_wdata),
            .pulse(pulse[i]), .cnt(cnt[i]), .ovf(ovf[i])
        );
    end

    // source selection; chained overflows are recomputed from counter state
    always_comb begin
        logic p1, p2, p3, p4, o1, o3;
        sel2 = {st_q.mode12[4], st_q.mode12[1]};
        sel3 = {st_q.mode34[5], st_q.mode34[0]};
        sel4 = {st_q.mode34[4], st_q.mode34[1]};
        p1 = st_q.mode12[0] ? tick_hi : tick_mid;
        o1 = p1 && !ld[0] && (cnt[0] == '0);
        case (sel2)
            2'b00:   p2 = tick_mid;
            2'b01:   p2 = o1;
            default: p2 = rise[0];
        endcase
        case (sel3)
            2'b00:   p3 = tick_mid;
            2'b01:   p3 = rise[1];
            default: p3 = rise[2];
        endcase
        o3 = p3 && !ld[2] && (cnt[2] == '0);
        case (sel4)
            2'b00:   p4 = tick_mid;
            2'b01:   p4 = tick_lo;
            default: p4 = o3;
        endcase
        pulse = {p4, p3, p2, p1};
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = (st_q.irq & ~irq_clr) | ovf;
        if (bus_wr && bus_addr == OFS_MODE12) st_d.mode12 = bus_wdata;
        if (bus_wr && bus_addr == OFS_MODE34) st_d.mode34 = bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < AW'(TMR_N))       bus_rdata = cnt[bus_addr[1:0]];
        else if (bus_addr == OFS_MODE12) bus_rdata = st_q.mode12;
        else if (bus_addr == OFS_MODE34) bus_rdata = st_q.mode34;
        irq_req = st_q.irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < TMR_N; i++) begin : g_flag_chk
        // R3
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] |=> irq_req[i]);
        // R4
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_clr[i] && !ovf[i]) |=> !irq_req[i]);
        // R4
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[i] && !irq_clr[i]) |=> irq_req[i]);
    end

    // R6
    chain12_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel2 == 2'b01) |-> (pulse[1] == ovf[0]));
    // R8
    chain34_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel4[1]) |-> (pulse[3] == ovf[2]));
endmodule

// File: tb/tb_qtmr_unit.sv
module tb_qtmr_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pin_t2_clk = 1'b0;
    logic       pin_line_sync = 1'b0;
    logic       pin_t3_clk = 1'b0;
    logic [3:0] irq_clr = '0;
    logic [3:0] irq_req;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    qtmr_unit dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_t2_clk(pin_t2_clk), .pin_line_sync(pin_line_sync),
        .pin_t3_clk(pin_t3_clk),
        .irq_clr(irq_clr), .irq_req(irq_req)
    );

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clr_flag(input int i);
        @(negedge clk);
        irq_clr[i] = 1'b1;
        @(negedge clk);
        irq_clr[i] = 1'b0;
    endtask

    task automatic wait_flag(input int i);
        while (!irq_req[i]) @(negedge clk);
    endtask

    // period in cycles between two overflows of timer i
    task automatic measure(input int i, input int exp, input string tag);
        int n;
        clr_flag(i);
        wait_flag(i);
        irq_clr[i] = 1'b1;
        @(negedge clk);
        irq_clr[i] = 1'b0;
        n = 1;
        while (!irq_req[i]) begin
            @(negedge clk);
            n++;
        end
        check(tag, n, exp);
    endtask

    task automatic pin_edge(input int p);
        @(negedge clk);
        if (p == 0) pin_t2_clk = 1'b1; else if (p == 1) pin_line_sync = 1'b1; else pin_t3_clk = 1'b1;
        repeat (4) @(negedge clk);
        if (p == 0) pin_t2_clk = 1'b0; else if (p == 1) pin_line_sync = 1'b0; else pin_t3_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), d);
            check("R10 counter reset", d, 8'hFF);
        end
        rd(3'd4, d); check("R10 mode12 reset", d, 0);
        rd(3'd5, d); check("R10 mode34 reset", d, 0);
        rd(3'd6, d); check("R10 unused offset", d, 0);
        check("R10 flags reset", irq_req, 0);
    endtask

    task automatic t_load;
        logic [7:0] d;
        wr(3'd0, 8'h5A);
        rd(3'd0, d);
        check("R2 latch write loads counter", d, 8'h5A);
        wr(3'd5, 8'h13);
        rd(3'd5, d);
        check("R10 mode34 readback", d, 8'h13);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_periods;
        wr(3'd4, 8'h00);
        wr(3'd0, 8'd3);
        measure(0, 64, "R1 timer1 f/16 n=3");
        wr(3'd4, 8'h01);
        wr(3'd0, 8'd0);
        measure(0, 4096, "R5 timer1 f/4096 n=0");
        wr(3'd5, 8'h02);
        wr(3'd3, 8'd4);
        measure(3, 10, "R8 timer4 f/2 n=4");
    endtask

    task automatic t_chain;
        wr(3'd4, 8'h02);
        wr(3'd0, 8'd1);
        wr(3'd1, 8'd2);
        measure(1, 96, "R6 timer1->timer2 chain");
        wr(3'd5, 8'h10);
        wr(3'd2, 8'd0);
        wr(3'd3, 8'd1);
        measure(3, 32, "R8 timer3->timer4 chain");
    endtask

    task automatic t_pins;
        logic [7:0] d;
        wr(3'd4, 8'h10);
        wr(3'd1, 8'hFF);
        for (int k = 0; k < 5; k++) pin_edge(0);
        rd(3'd1, d);
        check("R6 timer2 pin edges", d, 8'hFA);
        @(negedge clk);
        pin_t2_clk = 1'b1;
        repeat (20) @(negedge clk);
        rd(3'd1, d);
        check("R9 held pin counts once", d, 8'hF9);
        pin_t2_clk = 1'b0;
        repeat (4) @(negedge clk);

        wr(3'd5, 8'h01);
        wr(3'd2, 8'h10);
        for (int k = 0; k < 3; k++) pin_edge(1);
        rd(3'd2, d);
        check("R7 timer3 line-sync edges", d, 8'h0D);
        pin_edge(2); pin_edge(2);
        rd(3'd2, d);
        check("R7 unselected pin ignored", d, 8'h0D);
        wr(3'd5, 8'h20);
        pin_edge(2); pin_edge(2);
        pin_edge(1);
        rd(3'd2, d);
        check("R7 timer3 ext pin edges", d, 8'h0B);
    endtask

    task automatic t_reload_flags;
        logic [7:0] d;
        wr(3'd4, 8'h10);
        wr(3'd1, 8'd1);
        clr_flag(1);
        check("R4 flag cleared by strobe", irq_req[1], 0);
        pin_edge(0);
        rd(3'd1, d);
        check("R1 pin decrement to zero", d, 0);
        check("R3 no flag before overflow", irq_req[1], 0);
        pin_edge(0);
        rd(3'd1, d);
        check("R3 reload after overflow", d, 1);
        check("R3 flag set on overflow", irq_req[1], 1);
        repeat (10) @(negedge clk);
        check("R4 flag sticky", irq_req[1], 1);
        // set wins over clear in the same cycle
        wr(3'd1, 8'd0);
        @(negedge clk);
        pin_t2_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        irq_clr[1] = 1'b1;
        @(negedge clk);
        irq_clr[1] = 1'b0;
        #1 check("R4 set beats clear", irq_req[1], 1);
        pin_t2_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_periods();
        t_chain();
        t_pins();
        t_reload_flags();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule